// File: doc/BRIEF.md
# Two-Winding Microstep Sequencer

This block is a step/direction indexer for a two-winding bipolar stepping motor whose two bridge channels each accept a polarity bit, a two-bit current-level code and an active-low output enable. One step strobe moves the drive one position along the electrical cycle. The direction input chooses which way. A mode input chooses half stepping (8 positions per electrical cycle) or quarter stepping (16 positions). Finer resolution comes only from the discrete current codes. The analog current reference stays fixed, and the chopper and power stage lie outside this block.

Inside, the block keeps a single position counter with quarter-step resolution. Half stepping uses only the even positions of that counter. Because of this, changing the mode never loses the angle of the winding vector. A registered decoder turns the position into per-winding codes and polarities.

Top module: `microstep_seq`

## Requirements
- R1: While `rst_n` is low, the position is 0. `code_a` is 00 (full), `code_b` is 11 (zero), and `phase_a` and `phase_b` are 0.
- R2: `en_a` and `en_b` are 0 at all times (outputs on), in both modes.
- R3: In quarter mode (`quarter`=1), each clock edge that samples `step`=1 moves the position by one modulo 16. It moves up when `dir`=1 and down when `dir`=0.
- R4: In half mode (`quarter`=0), each sampled step moves the position by two modulo 16. The drive therefore cycles through 8 states, and each winding alternates between full and zero with both windings at 2/3 on the steps in between.
- R5: Current codes are 00 full, 01 two thirds, 10 one third and 11 zero. For position p, take the circular distance from p to the nearer of 0 and 8 for winding A, and to the nearer of 4 and 12 for winding B. A distance of 0 or 1 gives full, 2 gives 2/3, 3 gives 1/3 and 4 gives zero.
- R6: `phase_a` is 1 for positions 5 to 11 and 0 for positions 13 to 3. `phase_b` is 1 for positions 1 to 7 and 0 for positions 9 to 15.
- R7: While a winding's code is 11, its phase output keeps the value it had before.
- R8: The outputs change at the clock edge that samples the step strobe high. An edge that samples `step`=0 in quarter mode leaves every output unchanged.
- R9: In half mode, an odd position is first rounded down to the even position below it. A step sampled at the same edge is then applied from that rounded position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Step strobe; each edge sampled high is one step |
| dir | input | 1 | 1 = advance, 0 = retreat |
| quarter | input | 1 | 1 = quarter stepping (16 states), 0 = half stepping (8 states) |
| phase_a | output | 1 | Winding A polarity |
| code_a | output | 2 | Winding A current code |
| en_a | output | 1 | Winding A enable, active low |
| phase_b | output | 1 | Winding B polarity |
| code_b | output | 2 | Winding B current code |
| en_b | output | 1 | Winding B enable, active low |

## Verification
A change of mode and a step strobe can arrive at the same edge. If they do, the rounding of an odd position and the step of two must both take effect at that edge, in that order. The bench brings the drive to every odd position in quarter mode. It then drops to half mode, sometimes with a step in either direction at the same edge and sometimes with none. It judges the result by comparing both windings' codes and polarities with a position model kept in the bench.

// File: rtl/microstep_seq.sv
module microstep_seq #(
  parameter int POS_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       dir,
  input  logic       quarter,
  output logic       phase_a,
  output logic [1:0] code_a,
  output logic       en_a,
  output logic       phase_b,
  output logic [1:0] code_b,
  output logic       en_b
);

  localparam logic [1:0] C_FULL = 2'b00;
  localparam logic [1:0] C_TWO  = 2'b01;
  localparam logic [1:0] C_ONE  = 2'b10;
  localparam logic [1:0] C_ZERO = 2'b11;

  logic [POS_W-1:0] pos, base, pos_nx;
  logic [1:0]       major, minor, ca_nx, cb_nx;
  logic             pa_nx, pb_nx;

  assign base = quarter ? pos : {pos[POS_W-1:1], 1'b0};

  always_comb begin
    pos_nx = base;
    if (step) begin
      if (quarter) pos_nx = dir ? base + POS_W'(1) : base - POS_W'(1);
      else         pos_nx = dir ? base + POS_W'(2) : base - POS_W'(2);
    end
  end

  always_comb begin
    case (pos_nx[1:0])
      2'd0:    begin major = C_FULL; minor = C_ZERO; end
      2'd1:    begin major = C_FULL; minor = C_ONE;  end
      2'd2:    begin major = C_TWO;  minor = C_TWO;  end
      default: begin major = C_ONE;  minor = C_FULL; end
    endcase
  end

  assign ca_nx = pos_nx[2] ? minor : major;
  assign cb_nx = pos_nx[2] ? major : minor;
  assign pa_nx = (ca_nx == C_ZERO) ? phase_a : (pos_nx[3] ^ pos_nx[2]);
  assign pb_nx = (cb_nx == C_ZERO) ? phase_b : ~pos_nx[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos     <= '0;
      code_a  <= C_FULL;
      code_b  <= C_ZERO;
      phase_a <= 1'b0;
      phase_b <= 1'b0;
    end else begin
      pos     <= pos_nx;
      code_a  <= ca_nx;
      code_b  <= cb_nx;
      phase_a <= pa_nx;
      phase_b <= pb_nx;
    end
  end

  assign en_a = 1'b0;
  assign en_b = 1'b0;

  // R3
  quarter_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && quarter && dir) |=> pos == $past(pos) + POS_W'(1));

  // R3
  quarter_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && quarter && !dir) |=> pos == $past(pos) - POS_W'(1));

  // R9
  half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !quarter |=> !pos[0]);

  // R5
  a_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_a == C_ZERO) |-> (code_b == C_FULL));

  // R5
  b_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_b == C_ZERO) |-> (code_a == C_FULL));

  // R7
  a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_a == C_ZERO) |-> $stable(phase_a));

  // R7
  b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_b == C_ZERO) |-> $stable(phase_b));

  // R8
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && quarter) |=> ($stable(code_a) && $stable(code_b) &&
                            $stable(phase_a) && $stable(phase_b)));

endmodule

// File: tb/tb_microstep_seq.sv
module tb_microstep_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step = 1'b0, dir = 1'b1, quarter = 1'b1;
  logic phase_a, phase_b, en_a, en_b;
  logic [1:0] code_a, code_b;

  int checks = 0, failures = 0;
  int m_pos = 0;
  logic m_pa = 1'b0, m_pb = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  microstep_seq dut (
    .clk(clk), .rst_n(rst_n), .step(step), .dir(dir), .quarter(quarter),
    .phase_a(phase_a), .code_a(code_a), .en_a(en_a),
    .phase_b(phase_b), .code_b(code_b), .en_b(en_b)
  );

  function automatic int cdist(int p, int c);
    int d;
    d = (p - c + 16) % 16;
    return (d > 8) ? 16 - d : d;
  endfunction

  function automatic logic [1:0] lvl(int d);
    if (d <= 1) return 2'b00;
    if (d == 2) return 2'b01;
    if (d == 3) return 2'b10;
    return 2'b11;
  endfunction

  task automatic compare(string tag);
    logic [1:0] ea, eb;
    int da, db;
    da = cdist(m_pos, 0);  if (cdist(m_pos, 8) < da) da = cdist(m_pos, 8);
    db = cdist(m_pos, 4);  if (cdist(m_pos, 12) < db) db = cdist(m_pos, 12);
    ea = lvl(da);
    eb = lvl(db);
    if (m_pos > 4 && m_pos < 12) m_pa = 1'b1;
    else if (m_pos < 4 || m_pos > 12) m_pa = 1'b0;
    if (m_pos > 0 && m_pos < 8) m_pb = 1'b1;
    else if (m_pos > 8) m_pb = 1'b0;
    checks++;
    if (code_a !== ea || code_b !== eb || phase_a !== m_pa || phase_b !== m_pb) begin
      failures++;
      $display("FAIL %s pos=%0d actual a=%b/%b b=%b/%b expected a=%b/%b b=%b/%b",
               tag, m_pos, phase_a, code_a, phase_b, code_b, m_pa, ea, m_pb, eb);
    end
    checks++;
    if (en_a !== 1'b0 || en_b !== 1'b0) begin
      failures++;
      $display("FAIL R2 actual en=%b%b expected 00", en_a, en_b);
    end
  endtask

  task automatic cyc(bit s, bit d, bit q, string tag);
    @(negedge clk);
    step = s; dir = d; quarter = q;
    @(posedge clk);
    #1;
    if (!q) m_pos = m_pos & ~1;
    if (s) m_pos = (m_pos + (d ? 1 : -1) * (q ? 1 : 2) + 16) % 16;
    compare(tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compare("R1");
    @(negedge clk); rst_n = 1'b1;
    // R3 R5 R6 R7: quarter sweep up then down, with idle cycles (R8)
    for (int i = 0; i < 34; i++) begin
      cyc(1'b1, 1'b1, 1'b1, "R3");
      if (i % 5 == 0) cyc(1'b0, 1'b1, 1'b1, "R8");
    end
    for (int i = 0; i < 34; i++) begin
      cyc(1'b1, 1'b0, 1'b1, "R6");
      if (i % 7 == 0) cyc(1'b0, 1'b0, 1'b1, "R8");
    end
    // R4: half stepping both ways, wrapping
    for (int i = 0; i < 18; i++) cyc(1'b1, 1'b1, 1'b0, "R4");
    for (int i = 0; i < 18; i++) cyc(1'b1, 1'b0, 1'b0, "R4");
    // R9: mode drop at every odd position, with and without a step
    for (int i = 0; i < 48; i++) begin
      cyc(1'b1, 1'b1, 1'b1, "R5");
      if (m_pos % 2 == 1) begin
        cyc((i % 3) != 0, i[1], 1'b0, "R9");
        cyc(1'b0, 1'b1, 1'b1, "R9");
        cyc(1'b1, 1'b1, 1'b1, "R7");
      end
    end
    // R1: reset mid-cycle returns to position 0
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    m_pos = 0; m_pa = 1'b0; m_pb = 1'b0;
    compare("R1");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule